// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

The block sits between a host register port and an 8-bit NAND flash bus. The host first loads a command byte or an address byte into a holding register. It then sets a trigger bit in the trigger register, and the block runs one complete bus operation on its own: a command latch, an address latch, a data-in stream, a page read, an ID read or a status read. While the operation runs, the host polls a sticky done bit in the same register. Page data lives in an internal buffer of 512 main bytes and 16 spare bytes. The host sees that buffer as 16-bit words.

Each byte on the flash bus takes `T_LO` clocks with the write or read strobe low, then `T_HI` clocks with it high. A read-type byte is captured at the clock edge that ends its low phase. The host port is plain single-cycle register access: a write takes effect on the clock edge where `host_wr` is high, and `host_rdata` follows `host_addr` combinationally. There is no back-pressure at either edge. The host learns that the block is busy only from the done bit.

Top module: `nand_seq_top`

Host map (word addresses):

| Address | Content |
|---|---|
| 0x000–0x0FF | main buffer words |
| 0x100–0x107 | spare buffer words |
| 0x200 | command byte |
| 0x201 | address byte |
| 0x202 | mode: bit 2 spare-only, bit 3 ECC enable |
| 0x203 | triggers in bits 0–5, done in bit 15 |
| 0x204 | ECC status |

## Requirements
- R1: After reset, the bus is idle and the trigger register reads 0. Idle means CLE and ALE low, both strobes high and the data bus not driven.
- R2: Trigger bit 0 runs a command latch. The command byte is driven with CLE high, WE# is low for `T_LO` clocks and then high for `T_HI` clocks, and the block goes idle one clock after that.
- R3: Trigger bit 1 runs an address latch with the same timing. It drives the address byte with ALE high, and CLE and ALE are never high together.
- R4: Trigger bit 2 streams buffer bytes out with WE# pulses. It sends all 528 bytes, main area first and then spare. When mode bit 2 is set, it sends only the 16 spare bytes.
- R5: Trigger bit 3 first waits for R/B# to be high. It stays in that wait for at least one clock. It then reads 528 bytes, or 16 spare bytes when mode bit 2 is set, into the same buffer positions.
- R6: Trigger bit 4 reads 6 ID bytes into main bytes 0–5. Trigger bit 5 reads one status byte into main byte 0. No other buffer byte changes.
- R7: Bit 15 of the trigger register is set when an operation ends. Any host write to the trigger register clears it, unless an operation ends on that same edge, in which case bit 15 ends up set.
- R8: A trigger write made while an operation is running starts nothing and leaves the running operation untouched.
- R9: When a write sets several trigger bits, only the lowest-numbered one runs.
- R10: Buffer word w holds byte 2w in bits 7:0 and byte 2w+1 in bits 15:8. Host writes and reads use this mapping.
- R11: The mode register reads back bits 2 and 3. The ECC status register reads 0, so its uncorrectable mask 0xA is clear.
- R12: A trigger is accepted on the first clock after completion, without the host reading done. This holds also after a reset command (0xFF), which is sent like any other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| host_addr | input | 10 | host word address |
| host_wr | input | 1 | host write strobe |
| host_wdata | input | 16 | host write data |
| host_rdata | output | 16 | host read data, combinational from host_addr |
| nand_cle | output | 1 | command latch enable |
| nand_ale | output | 1 | address latch enable |
| nand_we_n | output | 1 | write strobe, active low |
| nand_re_n | output | 1 | read strobe, active low |
| nand_dq_out | output | 8 | byte driven to flash |
| nand_dq_oe | output | 1 | drive enable for nand_dq_out |
| nand_dq_in | input | 8 | byte from flash |
| nand_rb | input | 1 | ready (1) / busy (0) from flash |

## Verification
The completion of an operation and a host write to the trigger register can land on the same clock edge. That write can also carry a new trigger, which must be dropped because the block is still busy. The bench provokes this by issuing the write in the final high-phase clock of a command latch, using a trigger for an address latch. It then judges three things: the done bit must read set afterwards, no ALE cycle may appear on the bus, and only the command byte may have been latched. The cycle-level model also compares the strobe pins and the done bit on every clock. That includes the clock after completion, where a trigger must be accepted immediately.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    OP_CMD  = 3'd0,
    OP_ADR  = 3'd1,
    OP_DIN  = 3'd2,
    OP_POUT = 3'd3,
    OP_ID   = 3'd4,
    OP_STAT = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAITRB,
    ST_LOW,
    ST_HIGH
  } st_e;

  localparam int REG_CMD   = 'h200;
  localparam int REG_ADR   = 'h201;
  localparam int REG_MODE  = 'h202;
  localparam int REG_TRIG  = 'h203;
  localparam int REG_ECC   = 'h204;
  localparam int NUM_TRIG  = 6;
  localparam int DONE_BIT  = 15;
  localparam int SPARE_BIT = 2;
  localparam int ECC_BIT   = 3;
endpackage

// File: rtl/nand_seq_phase.sv
module nand_seq_phase #(
  parameter int T_LO = 2,
  parameter int T_HI = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_low,
  input  logic in_high,
  output logic lo_end,
  output logic hi_end
);
  localparam int TMAX = (T_LO > T_HI) ? T_LO : T_HI;
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;

  assign lo_end = in_low  && (cnt == CW'(T_LO - 1));
  assign hi_end = in_high && (cnt == CW'(T_HI - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (lo_end || hi_end || !(in_low || in_high)) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    in_low |-> (cnt < CW'(T_LO))) else $error("low phase overran"); // R2
endmodule

// File: rtl/nand_seq_buf.sv
module nand_seq_buf #(
  parameter int TOTAL = 528
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(TOTAL)-2:0]    h_word,
  input  logic                        h_wr,
  input  logic [15:0]                 h_wdata,
  output logic [15:0]                 h_rdata,
  input  logic [$clog2(TOTAL)-1:0]    e_idx,
  input  logic                        e_wr,
  input  logic [7:0]                  e_wdata,
  output logic [7:0]                  e_rdata
);
  localparam int IW = $clog2(TOTAL);

  logic [7:0] mem [TOTAL];

  always_ff @(posedge clk) begin
    if (h_wr) begin
      mem[{h_word, 1'b0}] <= h_wdata[7:0];
      mem[{h_word, 1'b1}] <= h_wdata[15:8];
    end
    if (e_wr) mem[e_idx] <= e_wdata;
  end

  assign h_rdata = {mem[{h_word, 1'b1}], mem[{h_word, 1'b0}]};
  assign e_rdata = mem[e_idx];

  AST_ENGINE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    e_wr |-> (e_idx < IW'(TOTAL))) else $error("engine index out of range"); // R6
endmodule

// File: rtl/nand_seq_top.sv
module nand_seq_top
  import nand_seq_pkg::*;
#(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int ID_BYTES    = 6,
  parameter int T_LO        = 2,
  parameter int T_HI        = 2,
  parameter int HADDR_W     = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic               host_wr,
  input  logic [15:0]        host_wdata,
  output logic [15:0]        host_rdata,
  output logic               nand_cle,
  output logic               nand_ale,
  output logic               nand_we_n,
  output logic               nand_re_n,
  output logic [7:0]         nand_dq_out,
  output logic               nand_dq_oe,
  input  logic [7:0]         nand_dq_in,
  input  logic               nand_rb
);
  localparam int TOTAL     = MAIN_BYTES + SPARE_BYTES;
  localparam int BUF_WORDS = TOTAL / 2;
  localparam int IW        = $clog2(TOTAL);
  localparam logic [HADDR_W-1:0] A_BUFEND = HADDR_W'(BUF_WORDS);
  localparam logic [HADDR_W-1:0] A_CMD    = HADDR_W'(REG_CMD);
  localparam logic [HADDR_W-1:0] A_ADR    = HADDR_W'(REG_ADR);
  localparam logic [HADDR_W-1:0] A_MODE   = HADDR_W'(REG_MODE);
  localparam logic [HADDR_W-1:0] A_TRIG   = HADDR_W'(REG_TRIG);

  logic [7:0]    cmd_q, adr_q;
  logic          spare_q, ecc_q, done_q;
  st_e           st;
  op_e           op_q, sel_op;
  logic [IW-1:0] idx_q, last_q, base_q, last_d, base_d;
  logic          lo_end, hi_end, finishing, is_read, active;
  logic          wr_trig, accept, in_buf;
  logic [15:0]   buf_rdata;
  logic [7:0]    e_rdata;

  assign in_buf  = host_addr < A_BUFEND;
  assign wr_trig = host_wr && (host_addr == A_TRIG);
  assign accept  = wr_trig && (st == ST_IDLE) && (|host_wdata[NUM_TRIG-1:0]);

  // lowest set trigger bit wins
  always_comb begin
    sel_op = OP_CMD;
    for (int i = NUM_TRIG - 1; i >= 0; i--)
      if (host_wdata[i]) sel_op = op_e'(3'(i));
  end

  always_comb begin
    base_d = '0;
    unique case (sel_op)
      OP_DIN, OP_POUT: begin
        last_d = spare_q ? IW'(SPARE_BYTES - 1) : IW'(TOTAL - 1);
        base_d = spare_q ? IW'(MAIN_BYTES) : '0;
      end
      OP_ID:   last_d = IW'(ID_BYTES - 1);
      default: last_d = '0;
    endcase
  end

  assign is_read   = (op_q == OP_POUT) || (op_q == OP_ID) || (op_q == OP_STAT);
  assign active    = (st == ST_LOW) || (st == ST_HIGH);
  assign finishing = hi_end && (idx_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      adr_q   <= '0;
      spare_q <= 1'b0;
      ecc_q   <= 1'b0;
      done_q  <= 1'b0;
      st      <= ST_IDLE;
      op_q    <= OP_CMD;
      idx_q   <= '0;
      last_q  <= '0;
      base_q  <= '0;
    end else begin
      if (host_wr && host_addr == A_CMD) cmd_q <= host_wdata[7:0];
      if (host_wr && host_addr == A_ADR) adr_q <= host_wdata[7:0];
      if (host_wr && host_addr == A_MODE) begin
        spare_q <= host_wdata[SPARE_BIT];
        ecc_q   <= host_wdata[ECC_BIT];
      end
      if (finishing)    done_q <= 1'b1;
      else if (wr_trig) done_q <= 1'b0;

      unique case (st)
        ST_IDLE: if (accept) begin
          op_q   <= sel_op;
          idx_q  <= '0;
          last_q <= last_d;
          base_q <= base_d;
          st     <= (sel_op == OP_POUT) ? ST_WAITRB : ST_LOW;
        end
        ST_WAITRB: if (nand_rb) st <= ST_LOW;
        ST_LOW:    if (lo_end) st <= ST_HIGH;
        ST_HIGH:   if (hi_end) begin
          if (idx_q == last_q) st <= ST_IDLE;
          else begin
            idx_q <= idx_q + 1'b1;
            st    <= ST_LOW;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  nand_seq_phase #(.T_LO(T_LO), .T_HI(T_HI)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_low  (st == ST_LOW),
    .in_high (st == ST_HIGH),
    .lo_end  (lo_end),
    .hi_end  (hi_end)
  );

  nand_seq_buf #(.TOTAL(TOTAL)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .h_word  (host_addr[IW-2:0]),
    .h_wr    (host_wr && in_buf),
    .h_wdata (host_wdata),
    .h_rdata (buf_rdata),
    .e_idx   (base_q + idx_q),
    .e_wr    (lo_end && is_read),
    .e_wdata (nand_dq_in),
    .e_rdata (e_rdata)
  );

  assign nand_cle    = active && (op_q == OP_CMD);
  assign nand_ale    = active && (op_q == OP_ADR);
  assign nand_we_n   = !((st == ST_LOW) && !is_read);
  assign nand_re_n   = !((st == ST_LOW) && is_read);
  assign nand_dq_oe  = active && !is_read;
  assign nand_dq_out = (op_q == OP_CMD) ? cmd_q : (op_q == OP_ADR) ? adr_q : e_rdata;

  always_comb begin
    host_rdata = '0;
    if (in_buf) host_rdata = buf_rdata;
    else if (host_addr == A_CMD) host_rdata = {8'h00, cmd_q};
    else if (host_addr == A_ADR) host_rdata = {8'h00, adr_q};
    else if (host_addr == A_MODE) begin
      host_rdata[SPARE_BIT] = spare_q;
      host_rdata[ECC_BIT]   = ecc_q;
    end
    else if (host_addr == A_TRIG) host_rdata[DONE_BIT] = done_q;
  end

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)) else $error("CLE and ALE together"); // R3
  AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    finishing |=> done_q) else $error("done not set"); // R7
  AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_trig && !finishing) |=> !done_q) else $error("done not cleared"); // R7
  AST_BUSY_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && wr_trig) |=> (op_q == $past(op_q))) else $error("op changed while busy"); // R8
  AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAITRB && !nand_rb) |=> (st == ST_WAITRB)) else $error("left wait while busy"); // R5
endmodule

// File: tb/tb_nand_seq_top.sv
module tb_nand_seq_top;
  localparam int TLO = 2, THI = 2;
  localparam logic [9:0] A_CMD = 10'h200, A_ADR = 10'h201, A_MODE = 10'h202,
                         A_TRIG = 10'h203, A_ECC = 10'h204;
  localparam int IDLE = 5'b00110, WMARK = 32;

  logic clk = 0, rst_n = 0;
  logic [9:0] host_addr = A_TRIG;
  logic host_wr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_out, nand_dq_in = 0;
  logic nand_rb = 0;

  nand_seq_top #(.T_LO(TLO), .T_HI(THI)) dut (.*);

  always #5 clk = ~clk;

  int chk = 0, err = 0;
  int q[$];
  int exp_wr[$], cap[$];
  logic [7:0] exp_buf [528];
  bit mbusy = 0, in_w = 0, exp_done = 0, wr2 = 0, spare_m = 0, rb_edge = 0;
  logic [7:0] m_cmd = 0, m_adr = 0;
  int seed = 0, rd_seq = 0;
  string tag = "R1";

  task automatic check(bit ok, string req, int act, int expv);
    chk++;
    if (!ok) begin
      err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [7:0] pat(int j, int s);
    return 8'((j * 7 + s) & 255);
  endfunction

  always @(negedge nand_re_n) begin
    nand_dq_in = pat(rd_seq, seed);
    rd_seq++;
  end
  always @(posedge nand_we_n) cap.push_back({nand_cle, nand_ale, nand_dq_out});
  always @(posedge clk) rb_edge <= nand_rb;

  // cycle model compared every clock
  always @(posedge clk) begin
    int e;
    #2;
    if (!rst_n) begin
      mbusy = 0; in_w = 0; exp_done = 0; wr2 = 0; q.delete();
    end else begin
      if (mbusy && q.size() == 0) exp_done = 1;
      else if (wr2) exp_done = 0;
      wr2 = 0;
      if (q.size() > 0) begin
        if (q[0] == WMARK) begin
          if (in_w && rb_edge) begin
            void'(q.pop_front()); in_w = 0; e = q.pop_front();
          end else begin
            in_w = 1; e = IDLE;
          end
        end else e = q.pop_front();
        mbusy = 1;
      end else begin
        e = IDLE; mbusy = 0;
      end
      check({nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe} == 5'(e), tag,
            {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe}, e);
      if (host_addr == A_TRIG)
        check(host_rdata[15] == exp_done, "R7", host_rdata[15], exp_done);
    end
  end

  task automatic push_op(logic [15:0] d);
    int b = 0, n, base;
    bit rd;
    for (int i = 5; i >= 0; i--) if (d[i]) b = i;
    rd = (b >= 3);
    n = (b == 4) ? 6 : (b == 2 || b == 3) ? (spare_m ? 16 : 528) : 1;
    base = ((b == 2 || b == 3) && spare_m) ? 512 : 0;
    if (b == 3) q.push_back(WMARK);
    for (int j = 0; j < n; j++) begin
      for (int k = 0; k < TLO; k++)
        q.push_back(rd ? 5'b00100 : {b == 0, b == 1, 3'b011});
      for (int k = 0; k < THI; k++)
        q.push_back(rd ? 5'b00110 : {b == 0, b == 1, 3'b111});
      if (rd) exp_buf[base + j] = pat(j, seed);
      else if (b == 0) exp_wr.push_back({2'b10, m_cmd});
      else if (b == 1) exp_wr.push_back({2'b01, m_adr});
      else exp_wr.push_back({2'b00, exp_buf[base + j]});
    end
  endtask

  task automatic hwrite(logic [9:0] a, logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1;
    if (a < 10'd264) begin
      exp_buf[2 * a] = d[7:0]; exp_buf[2 * a + 1] = d[15:8];
    end
    if (a == A_CMD) m_cmd = d[7:0];
    if (a == A_ADR) m_adr = d[7:0];
    if (a == A_MODE) spare_m = d[2];
    if (a == A_TRIG) begin
      wr2 = 1;
      if (!mbusy && d[5:0] != 0) push_op(d);
    end
    @(negedge clk);
    host_wr = 0; host_addr = A_TRIG;
  endtask

  task automatic hread(logic [9:0] a, output logic [15:0] v);
    host_addr = a; #1; v = host_rdata; host_addr = A_TRIG;
  endtask

  task automatic wait_idle();
    while (mbusy || q.size() > 0) @(negedge clk);
  endtask

  task automatic check_caps(string req);
    check(cap.size() == exp_wr.size(), req, cap.size(), exp_wr.size());
    for (int i = 0; i < cap.size() && i < exp_wr.size(); i++)
      if (cap[i] != exp_wr[i]) check(0, req, cap[i], exp_wr[i]);
    cap.delete(); exp_wr.delete();
  endtask

  task automatic check_buf(string req);
    logic [15:0] v;
    for (int w = 0; w < 264; w++) begin
      hread(10'(w), v);
      check(v == {exp_buf[2 * w + 1], exp_buf[2 * w]}, req, v, {exp_buf[2 * w + 1], exp_buf[2 * w]});
    end
  endtask

  task automatic run(logic [15:0] trig, int s);
    seed = s; rd_seq = 0;
    hwrite(A_TRIG, trig);
    wait_idle();
  endtask

  initial begin
    #1_500_000;
    check(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", err, chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cap.delete();
    // R1 reset state
    check({nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe} == 5'(IDLE), "R1",
          {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe}, IDLE);
    hread(A_TRIG, v); check(v == 0, "R1", v, 0);

    // R2 command latch
    tag = "R2"; hwrite(A_CMD, 16'h0080); run(16'h0001, 0); check_caps("R2");
    hread(A_TRIG, v); check(v[15], "R7", v, 16'h8000);
    // R3 address latch
    tag = "R3"; hwrite(A_ADR, 16'h0012); run(16'h0002, 0); check_caps("R3");

    // R10 host word lanes
    for (int w = 0; w < 264; w++) hwrite(10'(w), 16'((w * 257) ^ 16'hA55A));
    hread(10'd5, v); check(v[7:0] == exp_buf[10] && v[15:8] == exp_buf[11], "R10", v, {exp_buf[11], exp_buf[10]});
    check_buf("R10");

    // R4 data-in, full then spare-only
    tag = "R4"; run(16'h0004, 0); check_caps("R4");
    hwrite(A_MODE, 16'h0004); run(16'h0004, 0); check_caps("R4");

    // R11 mode readback and ECC stub
    hread(A_MODE, v); check(v == 16'h0004, "R11", v, 4);
    hwrite(A_MODE, 16'h0008); hread(A_MODE, v); check(v == 16'h0008, "R11", v, 8);
    hread(A_ECC, v); check((v & 16'h000A) == 0, "R11", v, 0);

    // R5 page-out waits for ready; R8 trigger while busy ignored
    tag = "R5"; seed = 3; rd_seq = 0;
    hwrite(A_TRIG, 16'h0008);
    repeat (4) @(negedge clk);
    hwrite(A_TRIG, 16'h0001);
    check(cap.size() == 0, "R8", cap.size(), 0);
    repeat (3) @(negedge clk);
    nand_rb = 1;
    wait_idle(); nand_rb = 0;
    check_caps("R8"); check_buf("R5");
    hwrite(A_MODE, 16'h0004);
    seed = 40; rd_seq = 0; hwrite(A_TRIG, 16'h0008);
    nand_rb = 1; wait_idle(); nand_rb = 0;
    check_buf("R5");
    hwrite(A_MODE, 16'h0000);

    // R6 ID and status
    tag = "R6"; run(16'h0010, 90); check_buf("R6");
    run(16'h0020, 200); check_buf("R6");

    // R9 priority: bits 1 and 2 set, address latch runs
    tag = "R9"; hwrite(A_ADR, 16'h0033); run(16'h0006, 0); check_caps("R9");

    // R7 completion coincides with trigger write; new trigger dropped
    tag = "R7"; hwrite(A_CMD, 16'h0090);
    seed = 0; hwrite(A_TRIG, 16'h0001);
    while (!(q.size() == 0 && mbusy)) @(negedge clk);
    hwrite(A_TRIG, 16'h0002);
    wait_idle();
    hread(A_TRIG, v); check(v[15], "R7", v, 16'h8000);
    check_caps("R7");
    hwrite(A_TRIG, 16'h0000); hread(A_TRIG, v); check(v == 0, "R7", v, 0);

    // R12 reset command then immediate trigger
    tag = "R12"; hwrite(A_CMD, 16'h00FF); run(16'h0001, 0);
    hwrite(A_CMD, 16'h0070); run(16'h0001, 0);
    check_caps("R12");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", err, chk);
    $finish;
  end
endmodule